// File: doc/BRIEF.md
# Ranked Channel Scan Sequencer

This block sequences conversions over six analog input channels of a converter front end. Software programs two 24-bit map words through a parallel write port. Each word holds three channels. For each channel the map gives a scan enable, an output-pin enable, a 3-bit rank and a 2-bit pin selector. The rank sets the scan order, and the channel index has no part in it.

The block checks the map every cycle and reports two status flags. The first covers rank faults: an illegal, out-of-range or repeated rank. The second covers two pin-driving channels that claim the same output pin. A start command runs only when the map is clean and at least one channel is enabled. During a scan the block presents the active channel index and drives that channel's mapped pin. It moves to the next rank on each conversion-done strobe, and it finishes with a one-cycle completion pulse. The map cannot be written while a scan is running.

Top module: `scan_seq_top`

## Requirements
- R1: After reset both map words read as zero, and `busy`, `pins`, `order_err`, `pin_err` and `scan_done` are all low.
- R2: A write with `wr_sel`=0 loads channels 0 to 2, and `wr_sel`=1 loads channels 3 to 5. Channel k uses byte k mod 3 of its word. In that byte, bit 0 is the pin enable, bit 1 is the scan enable, bits 4:2 are the rank and bits 6:5 are the pin selector. Bit 7 is not stored and reads as 0. `rd_data` shows the word chosen by `rd_sel` in the same cycle.
- R3: `order_err` is high when any scan-enabled channel has rank 0, rank 7, a rank above the number of scan-enabled channels, or the same rank as another scan-enabled channel. Channels that are not scan-enabled never affect it.
- R4: `pin_err` is high when two or more channels that have both enables set hold the same pin selector.
- R5: A write issued while `busy` is high leaves both map words unchanged.
- R6: A start while either flag is high, or while no channel is scan-enabled, is refused: `busy` stays low and every pin stays low.
- R7: An accepted start raises `busy` on the next clock with `ch_sel` set to the channel of rank 1. Each `conv_done` strobe moves `ch_sel` to the channel of the next rank.
- R8: While `busy` is high and the active channel has its pin enable set, exactly one pin is high: pin bit 0 for selector 0, bit 1 for selector 1, bit 2 for selector 2, bit 3 for selector 3. At all other times `pins` is zero.
- R9: On the clock after `conv_done` for the last rank, `busy` falls, `pins` clears and `scan_done` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Map write strobe |
| wr_sel | input | 1 | Map word to write |
| wr_data | input | 24 | Map write data |
| rd_sel | input | 1 | Map word to read |
| rd_data | output | 24 | Map read data |
| start | input | 1 | Scan start request |
| conv_done | input | 1 | Conversion-done strobe for the active channel |
| busy | output | 1 | Scan in progress |
| ch_sel | output | 3 | Active channel index |
| pins | output | 4 | Output pin drive, one bit per pin |
| order_err | output | 1 | Rank fault flag |
| pin_err | output | 1 | Pin conflict flag |
| scan_done | output | 1 | One-cycle scan completion pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the map words hold steady while `busy` is high;
- at most one pin is driven, and no pin is driven when idle;
- a refused start never raises `busy`;
- while busy, the current rank stays between one and the enabled count and always matches some channel;
- the completion pulse lasts one cycle.

The bench sweeps every combination of the six scan enables under four rank and pin patterns. Only these scenarios can show that the flags match an arithmetic model of the rules and that the byte layout is correct. They also show that scans visit channels in rank order rather than index order.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
   localparam int RANK_W  = 3;
   localparam int PSEL_W  = 2;
   localparam int CFG_W   = RANK_W + PSEL_W + 2;

   // Field order from LSB: pin enable, scan enable, rank, pin selector
   typedef struct packed {
      logic [PSEL_W-1:0] psel;
      logic [RANK_W-1:0] rank;
      logic              scan_en;
      logic              pin_en;
   } chan_cfg_t;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } scan_state_e;
endpackage

// File: rtl/scan_map_regs.sv
module scan_map_regs
   import scan_seq_pkg::*;
#(
   parameter int N_CH     = 6,
   parameter int PER_WORD = 3,
   parameter int SLOT_W   = 8,
   localparam int N_WORDS = N_CH / PER_WORD,
   localparam int SEL_W   = $clog2(N_WORDS),
   localparam int WORD_W  = PER_WORD * SLOT_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lock,
   input  logic                   wr_en,
   input  logic [SEL_W-1:0]       wr_sel,
   input  logic [WORD_W-1:0]      wr_data,
   input  logic [SEL_W-1:0]       rd_sel,
   output logic [WORD_W-1:0]      rd_data,
   output chan_cfg_t [N_CH-1:0]   cfg_o
);
   chan_cfg_t [N_CH-1:0] cfg_q;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      localparam int WORD_IDX = g / PER_WORD;
      localparam int SLOT_IDX = g % PER_WORD;
      logic hit;
      assign hit = wr_en && !lock && (wr_sel == SEL_W'(WORD_IDX));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cfg_q[g] <= '0;
         else if (hit) cfg_q[g] <= chan_cfg_t'(wr_data[SLOT_IDX*SLOT_W +: CFG_W]);
      end
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < N_WORDS; w++) begin
         if (rd_sel == SEL_W'(w)) begin
            for (int j = 0; j < PER_WORD; j++)
               rd_data[j*SLOT_W +: CFG_W] = cfg_q[w*PER_WORD + j];
         end
      end
   end

   assign cfg_o = cfg_q;

   AST_MAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(cfg_q)); // R5
endmodule

// File: rtl/scan_map_check.sv
module scan_map_check
   import scan_seq_pkg::*;
#(
   parameter int N_CH   = 6,
   localparam int CNT_W = $clog2(N_CH + 1)
) (
   input  chan_cfg_t [N_CH-1:0] cfg_i,
   output logic [CNT_W-1:0]     n_en,
   output logic                 order_err,
   output logic                 pin_err
);
   logic [N_CH-1:0] bad_rank;
   logic [N_CH-1:0] drives;
   logic            dup_rank;
   logic            dup_pin;

   always_comb begin
      n_en = '0;
      for (int i = 0; i < N_CH; i++)
         n_en = n_en + CNT_W'(cfg_i[i].scan_en);
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_rank
      assign bad_rank[g] = cfg_i[g].scan_en &&
                           ((cfg_i[g].rank == '0) || (cfg_i[g].rank == '1) ||
                            (32'(cfg_i[g].rank) > 32'(n_en)));
      assign drives[g]   = cfg_i[g].scan_en && cfg_i[g].pin_en;
   end

   always_comb begin
      dup_rank = 1'b0;
      dup_pin  = 1'b0;
      for (int i = 0; i < N_CH; i++) begin
         for (int j = i + 1; j < N_CH; j++) begin
            if (cfg_i[i].scan_en && cfg_i[j].scan_en && (cfg_i[i].rank == cfg_i[j].rank))
               dup_rank = 1'b1;
            if (drives[i] && drives[j] && (cfg_i[i].psel == cfg_i[j].psel))
               dup_pin = 1'b1;
         end
      end
   end

   assign order_err = (|bad_rank) || dup_rank;
   assign pin_err   = dup_pin;
endmodule

// File: rtl/scan_engine.sv
module scan_engine
   import scan_seq_pkg::*;
#(
   parameter int N_CH    = 6,
   localparam int CNT_W  = $clog2(N_CH + 1),
   localparam int CH_W   = $clog2(N_CH),
   localparam int PIN_N  = 1 << PSEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  chan_cfg_t [N_CH-1:0] cfg_i,
   input  logic [CNT_W-1:0]     n_en,
   input  logic                 map_ok,
   input  logic                 start,
   input  logic                 conv_done,
   output logic                 busy,
   output logic [CH_W-1:0]      ch_sel,
   output logic [PIN_N-1:0]     pins,
   output logic                 scan_done
);
   scan_state_e       state_q;
   logic [RANK_W-1:0] rank_q;
   logic              hit;
   logic              sel_pe;
   logic [PSEL_W-1:0] sel_ps;
   logic              last;

   always_comb begin
      hit    = 1'b0;
      ch_sel = '0;
      sel_pe = 1'b0;
      sel_ps = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (cfg_i[i].scan_en && (cfg_i[i].rank == rank_q)) begin
            hit    = 1'b1;
            ch_sel = CH_W'(i);
            sel_pe = cfg_i[i].pin_en;
            sel_ps = cfg_i[i].psel;
         end
      end
   end

   assign busy = (state_q == ST_CONV);
   assign last = (32'(rank_q) == 32'(n_en));

   always_comb begin
      pins = '0;
      if (busy && hit && sel_pe) pins[sel_ps] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rank_q    <= '0;
         scan_done <= 1'b0;
      end else begin
         scan_done <= 1'b0;
         case (state_q)
            ST_IDLE: if (start && map_ok) begin
               state_q <= ST_CONV;
               rank_q  <= RANK_W'(1);
            end
            ST_CONV: if (conv_done) begin
               if (last) begin
                  state_q   <= ST_IDLE;
                  rank_q    <= '0;
                  scan_done <= 1'b1;
               end else begin
                  rank_q <= rank_q + RANK_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_PINS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pins)); // R8
   AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pins == '0)); // R8
   AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !map_ok) |=> !busy); // R6
   AST_RANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (hit && rank_q != '0 && 32'(rank_q) <= 32'(n_en))); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done); // R9
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
   import scan_seq_pkg::*;
#(
   parameter int N_CH     = 6,
   parameter int PER_WORD = 3,
   parameter int SLOT_W   = 8,
   localparam int N_WORDS = N_CH / PER_WORD,
   localparam int SEL_W   = $clog2(N_WORDS),
   localparam int WORD_W  = PER_WORD * SLOT_W,
   localparam int CNT_W   = $clog2(N_CH + 1),
   localparam int CH_W    = $clog2(N_CH),
   localparam int PIN_N   = 1 << PSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_data,
   input  logic              start,
   input  logic              conv_done,
   output logic              busy,
   output logic [CH_W-1:0]   ch_sel,
   output logic [PIN_N-1:0]  pins,
   output logic              order_err,
   output logic              pin_err,
   output logic              scan_done
);
   if (N_CH % PER_WORD != 0) begin : g_bad_split
      $error("N_CH must be a multiple of PER_WORD");
   end
   if (N_WORDS < 2) begin : g_bad_words
      $error("at least two map words are required");
   end
   if (SLOT_W < CFG_W) begin : g_bad_slot
      $error("SLOT_W too narrow for a channel entry");
   end
   if (N_CH > (1 << RANK_W) - 2) begin : g_bad_rank
      $error("rank field cannot order N_CH channels");
   end

   chan_cfg_t [N_CH-1:0] cfg;
   logic [CNT_W-1:0]     n_en;
   logic                 map_ok;

   scan_map_regs #(.N_CH(N_CH), .PER_WORD(PER_WORD), .SLOT_W(SLOT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .lock(busy),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .cfg_o(cfg)
   );

   scan_map_check #(.N_CH(N_CH)) u_check (
      .cfg_i(cfg), .n_en(n_en), .order_err(order_err), .pin_err(pin_err)
   );

   assign map_ok = !order_err && !pin_err && (n_en != '0);

   scan_engine #(.N_CH(N_CH)) u_engine (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .n_en(n_en), .map_ok(map_ok),
      .start(start), .conv_done(conv_done), .busy(busy), .ch_sel(ch_sel),
      .pins(pins), .scan_done(scan_done)
   );
endmodule

// File: tb/scan_seq_top_tb.sv
module scan_seq_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [23:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [23:0] rd_data;
   logic        start = 1'b0;
   logic        conv_done = 1'b0;
   logic        busy;
   logic [2:0]  ch_sel;
   logic [3:0]  pins;
   logic        order_err, pin_err, scan_done;

   int checks = 0;
   int errors = 0;
   int en[NCH], pe[NCH], rk[NCH], ps[NCH];
   int nen;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_seq_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .start(start), .conv_done(conv_done),
      .busy(busy), .ch_sel(ch_sel), .pins(pins), .order_err(order_err),
      .pin_err(pin_err), .scan_done(scan_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   function automatic logic [23:0] pack_word(input int w, input bit junk);
      logic [23:0] d = '0;
      for (int j = 0; j < 3; j++) begin
         int c = w*3 + j;
         d[j*8 +: 8] = {junk, 2'(ps[c]), 3'(rk[c]), 1'(en[c]), 1'(pe[c])};
      end
      return d;
   endfunction

   function automatic bit model_oerr();
      for (int i = 0; i < NCH; i++) begin
         if (en[i] != 0) begin
            if (rk[i] == 0 || rk[i] == 7 || rk[i] > nen) return 1'b1;
            for (int j = i + 1; j < NCH; j++)
               if (en[j] != 0 && rk[j] == rk[i]) return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   function automatic bit model_perr();
      for (int i = 0; i < NCH; i++)
         for (int j = i + 1; j < NCH; j++)
            if (en[i] != 0 && pe[i] != 0 && en[j] != 0 && pe[j] != 0 && ps[i] == ps[j])
               return 1'b1;
      return 1'b0;
   endfunction

   task automatic build(input int mask, input int v);
      int pos = 0;
      int first = -1;
      int lastc = -1;
      nen = $countones(mask[5:0]);
      for (int c = 0; c < NCH; c++) begin
         en[c] = mask[c];
         if (en[c] == 0) begin
            rk[c] = 7; ps[c] = 0; pe[c] = 1;
         end else begin
            pos++;
            if (first < 0) first = c;
            lastc = c;
            case (v)
               0: begin rk[c] = pos;           ps[c] = c % 4;       pe[c] = (c < 4); end
               1: begin rk[c] = nen + 1 - pos; ps[c] = c % 4;       pe[c] = 1;       end
               2: begin rk[c] = pos;           ps[c] = (c / 2) % 4; pe[c] = 1;       end
               default: begin rk[c] = pos;     ps[c] = 3 - c % 4;   pe[c] = (c >= 2); end
            endcase
         end
      end
      if (v == 2 && nen >= 2) rk[lastc] = 1;
      if (v == 3 && first >= 0) rk[first] = mask[0] ? 7 : nen + 1;
   endtask

   task automatic run_scan();
      logic [23:0] w0;
      rd_sel = 1'b0; #1;
      w0 = rd_data;
      start = 1'b1; tick(); start = 1'b0;
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      for (int r = 1; r <= nen; r++) begin
         int ec = 0;
         int ep;
         for (int c = 0; c < NCH; c++) if (en[c] != 0 && rk[c] == r) ec = c;
         ep = (pe[ec] != 0) ? (1 << ps[ec]) : 0;
         chk(ch_sel == 3'(ec), "R7 channel by rank", ch_sel, ec);
         chk(pins == 4'(ep), "R8 pin drive", pins, ep);
         if (r == 1) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = 24'h7f7f7f;
            tick();
            wr_en = 1'b0;
            rd_sel = 1'b0; #1;
            chk(rd_data == w0, "R5 write while busy", rd_data, w0);
            chk(ch_sel == 3'(ec), "R5 channel held", ch_sel, ec);
         end
         conv_done = 1'b1; tick(); conv_done = 1'b0;
      end
      chk(scan_done && !busy && pins == 0, "R9 completion",
          {scan_done, busy, pins}, 6'b100000);
      tick();
      chk(scan_done == 1'b0, "R9 pulse width", scan_done, 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      rd_sel = 1'b0; #1;
      chk(rd_data == 0, "R1 word0 reset", rd_data, 0);
      rd_sel = 1'b1; #1;
      chk(rd_data == 0, "R1 word1 reset", rd_data, 0);
      chk({busy, pins, order_err, pin_err, scan_done} == 0, "R1 outputs reset",
          {busy, pins, order_err, pin_err, scan_done}, 0);

      for (int mask = 0; mask < 64; mask++) begin
         for (int v = 0; v < 4; v++) begin
            bit eo, ep;
            build(mask, v);
            for (int w = 0; w < 2; w++) begin
               wr_en = 1'b1; wr_sel = w[0]; wr_data = pack_word(w, v == 1);
               tick();
            end
            wr_en = 1'b0;
            for (int w = 0; w < 2; w++) begin
               rd_sel = w[0]; #1;
               chk(rd_data == pack_word(w, 1'b0), "R2 map readback", rd_data, pack_word(w, 1'b0));
            end
            eo = model_oerr();
            ep = model_perr();
            chk(order_err == eo, "R3 order flag", order_err, eo);
            chk(pin_err == ep, "R4 pin flag", pin_err, ep);
            if (!eo && !ep && nen > 0) begin
               run_scan();
            end else begin
               start = 1'b1; tick(); start = 1'b0;
               chk(!busy && pins == 0, "R6 start refused", {busy, pins}, 0);
               tick();
               chk(!busy, "R6 still idle", busy, 0);
            end
         end
      end
      summary();
   end
endmodule